// File: doc/BRIEF.md
# High-Speed Lane Transmit Sequencer

This block drives one transmit-only differential serial lane. When idle the lane sits in the low-power stop state, with both wires high. A burst request moves the lane through a series of low-power line states and a high-speed zero preamble. Each of these phases has its own length, set by a timing register counted in reference clock cycles. The block then sends a sync byte and the payload with two bits per clock period, holds a trailer level, and goes back to the stop state.

Payload bytes are written in advance into a register array for the lane. They stay there while the lane makes its transition. The block never receives and never turns the bus around. A floor parameter sets the minimum number of cycles from leaving the stop state to the first sync bit. The sequencer stretches the zero preamble whenever the programmed intervals add up to less than that floor. At 200 MHz the default floor of 120 cycles gives 600 ns. The timing inputs must stay stable while a burst is running.

Top module: `hs_lane_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, the lane is in the stop state: `lp_p`=1, `lp_n`=1, `hs_en`=0, `hs_bits`=00.
- R2: A start that is accepted raises `busy` in the next cycle. The lane then shows LP-01 (`lp_p`=0, `lp_n`=1) for `t_lp01`+1 cycles, followed by LP-00 (both 0) for `t_lp00`+1 cycles.
- R3: After LP-00 the lane enters the high-speed zero preamble: `hs_en`=1, `hs_bits`=00. The preamble lasts at least `t_zero`+1 cycles.
- R4: The first sync cycle comes exactly max(`t_lp01`+`t_lp00`+`t_zero`+3, MIN_PREP_CYC) cycles after the first LP-01 cycle.
- R5: The sync byte 0xB8 is sent over 4 cycles, LSB first. In each cycle `hs_bits[0]` carries the earlier bit, sent on the rising edge, and `hs_bits[1]` carries the later bit, sent on the falling edge.
- R6: The payload follows the sync byte. It is buffer entries 0 to `burst_len`-1 in address order, each sent LSB first over 4 cycles.
- R7: After the last payload cycle, both bits of `hs_bits` equal the inverse of bit 7 of the last byte, for `t_trail`+1 cycles. The next cycle is the stop state with `busy` low.
- R8: A start request is ignored when `burst_len` is 0, when it is above DEPTH, or when `busy` is high.
- R9: A write while `busy` is low stores `wr_data` at `wr_addr`. A write while `busy` is high leaves the buffer unchanged.
- R10: While `hs_en` is 1 both low-power levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | $clog2(DEPTH) | Buffer write address |
| wr_data | input | 8 | Buffer write byte |
| start | input | 1 | Burst request |
| burst_len | input | $clog2(DEPTH+1) | Payload byte count |
| t_lp01 | input | CNT_W | LP-01 interval minus one |
| t_lp00 | input | CNT_W | LP-00 interval minus one |
| t_zero | input | CNT_W | Minimum zero preamble minus one |
| t_trail | input | CNT_W | Trailer interval minus one |
| lp_p | output | 1 | Low-power level, positive wire |
| lp_n | output | 1 | Low-power level, negative wire |
| hs_en | output | 1 | High-speed driver enable |
| hs_bits | output | 2 | Bit pair for this clock period, [0] rising edge |
| busy | output | 1 | Burst in progress |

## Verification
The bench builds the block with DEPTH=8, CNT_W=4 and MIN_PREP_CYC=8. Every legal burst length is then cheap to run. The sweep covers each length against sixteen combinations of the four intervals. Some of these combinations add up to less than the floor, so the preamble gets stretched; the others exceed it, so the programmed intervals set the length. The small depth also brings the length-above-DEPTH rejection within reach, along with a write and a restart request issued while a burst is running.

// File: rtl/hs_lane_pkg.sv
package hs_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LP01, ST_LP00, ST_HSZ, ST_SYNC, ST_DATA, ST_TRAIL
  } seq_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'hB8;
endpackage

// File: rtl/hs_lane_buf.sv
module hs_lane_buf #(
  parameter int DEPTH = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hit;
    assign hit = we && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (hit) mem[i] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hs_lane_fsm.sv
module hs_lane_fsm import hs_lane_pkg::*; #(
  parameter int DEPTH        = 128,
  parameter int CNT_W        = 8,
  parameter int MIN_PREP_CYC = 120,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int PREP_W = $clog2(MIN_PREP_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  t_lp01,
  input  logic [CNT_W-1:0]  t_lp00,
  input  logic [CNT_W-1:0]  t_zero,
  input  logic [CNT_W-1:0]  t_trail,
  output seq_state_e        st,
  output logic [1:0]        pair,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy
);
  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [PREP_W-1:0] prep_q, prep_d, prep_inc;
  logic [1:0]        pair_q, pair_d;
  logic [ADDR_W-1:0] byte_q, byte_d, last_q, last_d;
  logic [LEN_W-1:0]  len_m1;
  logic              len_ok, prep_ok, adv_en;

  assign len_m1   = burst_len - LEN_W'(1);
  assign len_ok   = (burst_len != '0) && (burst_len <= LEN_W'(DEPTH));
  assign cnt_inc  = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + CNT_W'(1);
  assign prep_inc = (prep_q == PREP_W'(MIN_PREP_CYC)) ? prep_q : prep_q + PREP_W'(1);
  assign prep_ok  = prep_q >= PREP_W'(MIN_PREP_CYC - 1);
  assign adv_en   = (st_q != ST_IDLE) || start;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    prep_d = prep_q;
    pair_d = pair_q;
    byte_d = byte_q;
    last_d = last_q;
    case (st_q)
      ST_IDLE: if (start && len_ok) begin
        st_d   = ST_LP01;
        cnt_d  = '0;
        prep_d = '0;
        last_d = len_m1[ADDR_W-1:0];
      end
      ST_LP01: begin
        prep_d = prep_inc;
        if (cnt_q == t_lp01) begin
          st_d  = ST_LP00;
          cnt_d = '0;
        end else cnt_d = cnt_inc;
      end
      ST_LP00: begin
        prep_d = prep_inc;
        if (cnt_q == t_lp00) begin
          st_d  = ST_HSZ;
          cnt_d = '0;
        end else cnt_d = cnt_inc;
      end
      ST_HSZ: begin
        prep_d = prep_inc;
        cnt_d  = cnt_inc;
        if ((cnt_q >= t_zero) && prep_ok) begin
          st_d   = ST_SYNC;
          pair_d = 2'd0;
        end
      end
      ST_SYNC: begin
        pair_d = pair_q + 2'd1;
        if (pair_q == 2'd3) begin
          st_d   = ST_DATA;
          byte_d = '0;
        end
      end
      ST_DATA: begin
        pair_d = pair_q + 2'd1;
        if (pair_q == 2'd3) begin
          if (byte_q == last_q) begin
            st_d  = ST_TRAIL;
            cnt_d = '0;
          end else byte_d = byte_q + ADDR_W'(1);
        end
      end
      ST_TRAIL: begin
        if (cnt_q == t_trail) st_d = ST_IDLE;
        else cnt_d = cnt_inc;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      prep_q <= '0;
      pair_q <= '0;
      byte_q <= '0;
      last_q <= '0;
    end else if (adv_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      prep_q <= prep_d;
      pair_q <= pair_d;
      byte_q <= byte_d;
      last_q <= last_d;
    end
  end

  assign st      = st_q;
  assign pair    = pair_q;
  assign rd_addr = byte_q;
  assign busy    = (st_q != ST_IDLE);
endmodule

// File: rtl/hs_lane_ser.sv
module hs_lane_ser import hs_lane_pkg::*; (
  input  seq_state_e st,
  input  logic [1:0] pair,
  input  logic [7:0] rd_data,
  output logic       lp_p,
  output logic       lp_n,
  output logic       hs_en,
  output logic [1:0] hs_bits
);
  always_comb begin
    lp_p    = 1'b0;
    lp_n    = 1'b0;
    hs_en   = 1'b1;
    hs_bits = 2'b00;
    case (st)
      ST_IDLE: begin
        lp_p  = 1'b1;
        lp_n  = 1'b1;
        hs_en = 1'b0;
      end
      ST_LP01: begin
        lp_n  = 1'b1;
        hs_en = 1'b0;
      end
      ST_LP00:  hs_en   = 1'b0;
      ST_SYNC:  hs_bits = SYNC_BYTE[{pair, 1'b0} +: 2];
      ST_DATA:  hs_bits = rd_data[{pair, 1'b0} +: 2];
      ST_TRAIL: hs_bits = {2{~rd_data[7]}};
      default:  hs_bits = 2'b00;
    endcase
  end
endmodule

// File: rtl/hs_lane_tx.sv
module hs_lane_tx import hs_lane_pkg::*; #(
  parameter int DEPTH        = 128,
  parameter int CNT_W        = 8,
  parameter int MIN_PREP_CYC = 120,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              start,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  t_lp01,
  input  logic [CNT_W-1:0]  t_lp00,
  input  logic [CNT_W-1:0]  t_zero,
  input  logic [CNT_W-1:0]  t_trail,
  output logic              lp_p,
  output logic              lp_n,
  output logic              hs_en,
  output logic [1:0]        hs_bits,
  output logic              busy
);
  seq_state_e        st;
  logic [1:0]        pair;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  hs_lane_buf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .we      (wr_en && !busy),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  hs_lane_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W), .MIN_PREP_CYC(MIN_PREP_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .burst_len (burst_len),
    .t_lp01    (t_lp01),
    .t_lp00    (t_lp00),
    .t_zero    (t_zero),
    .t_trail   (t_trail),
    .st        (st),
    .pair      (pair),
    .rd_addr   (rd_addr),
    .busy      (busy)
  );

  hs_lane_ser u_ser (
    .st      (st),
    .pair    (pair),
    .rd_data (rd_data),
    .lp_p    (lp_p),
    .lp_n    (lp_n),
    .hs_en   (hs_en),
    .hs_bits (hs_bits)
  );
endmodule

// File: rtl/hs_lane_tx_chk.sv
module hs_lane_tx_chk import hs_lane_pkg::*; #(
  parameter int MIN_PREP_CYC = 120,
  localparam int PW = $clog2(MIN_PREP_CYC + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       lp_p,
  input logic       lp_n,
  input logic       hs_en,
  input logic [1:0] hs_bits,
  input seq_state_e st
);
  logic [PW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= '0;
    else if (!busy) since_q <= '0;
    else if (since_q != PW'(MIN_PREP_CYC)) since_q <= since_q + PW'(1);
  end

  // R1
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lp_p && lp_n && !hs_en && hs_bits == 2'b00));

  // R2
  lp01_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!lp_p && lp_n && !hs_en));

  // R3
  hs_from_lp00_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(!lp_p && !lp_n) && hs_bits == 2'b00));

  // R4
  prep_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC) |-> (since_q == PW'(MIN_PREP_CYC)));

  // R7
  exit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> (lp_p && lp_n && !busy));

  // R10
  hs_lp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (!lp_p && !lp_n));
endmodule

bind hs_lane_tx hs_lane_tx_chk #(.MIN_PREP_CYC(MIN_PREP_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .lp_p    (lp_p),
  .lp_n    (lp_n),
  .hs_en   (hs_en),
  .hs_bits (hs_bits),
  .st      (st)
);

// File: tb/hs_lane_tx_bench.sv
`timescale 1ns/1ps
module hs_lane_tx_bench;
  localparam int DEPTH = 8;
  localparam int CNT_W = 4;
  localparam int MINP  = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk, rst_n, wr_en, start;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [LW-1:0] burst_len;
  logic [CNT_W-1:0] t_lp01, t_lp00, t_zero, t_trail;
  logic lp_p, lp_n, hs_en, busy;
  logic [1:0] hs_bits;

  int tests, fails;
  logic [7:0] refm [DEPTH];

  hs_lane_tx #(.DEPTH(DEPTH), .CNT_W(CNT_W), .MIN_PREP_CYC(MINP)) u_hs_lane_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .burst_len(burst_len), .t_lp01(t_lp01), .t_lp00(t_lp00),
    .t_zero(t_zero), .t_trail(t_trail), .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en),
    .hs_bits(hs_bits), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // pack as {busy, lp_p, lp_n, hs_en, hs_bits}
  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {busy, lp_p, lp_n, hs_en, hs_bits};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_burst(input int len, input int a, input int b, input int z,
                           input int tr, input bit disturb);
    int p, total;
    logic [1:0] bits;
    p = a + b + z + 3;
    if (p < MINP) p = MINP;
    total = p + 4 + 4 * len + tr + 1;
    @(negedge clk);
    t_lp01 = CNT_W'(a); t_lp00 = CNT_W'(b); t_zero = CNT_W'(z); t_trail = CNT_W'(tr);
    burst_len = LW'(len); start = 1'b1;
    for (int k = 0; k <= total + 1; k++) begin
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      if (k <= a) check("R2", 6'b101000);
      else if (k <= a + b + 1) check("R2", 6'b100000);
      else if (k < p) check("R3", 6'b100100);
      else if (k < p + 4) begin
        bits = 2'((8'hB8 >> (2 * (k - p))) & 8'h3);
        check((k == p) ? "R4" : "R5", {4'b1001, bits});
      end else if (k < p + 4 + 4 * len) begin
        bits = 2'((refm[(k - p - 4) / 4] >> (2 * ((k - p - 4) % 4))) & 8'h3);
        check("R6", {4'b1001, bits});
      end else if (k < total) check("R7", {4'b1001, {2{~refm[len - 1][7]}}});
      else check((k == total) ? "R7" : "R8", 6'b011000);
      if (disturb && k == 0) begin
        // R9: write during burst must not alter byte 0
        wr_en = 1'b1; wr_addr = '0; wr_data = ~refm[0];
      end
      if (disturb && k == 5) begin
        // R8: restart while busy is ignored
        start = 1'b1; burst_len = LW'(1);
      end
    end
  endtask

  task automatic try_reject(input int len);
    @(negedge clk);
    burst_len = LW'(len); start = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      start = 1'b0;
      check("R8", 6'b011000);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; wr_addr = '0; wr_data = '0;
    burst_len = '0; t_lp01 = '0; t_lp00 = '0; t_zero = '0; t_trail = '0;
    repeat (3) @(negedge clk);
    check("R1", 6'b011000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 6'b011000);
    try_reject(0);
    try_reject(DEPTH + 1);
    for (int len = 1; len <= DEPTH; len++) begin
      for (int c = 0; c < 16; c++) begin
        for (int i = 0; i < len; i++) begin
          refm[i] = 8'((i * 37 + len * 11 + c * 53 + 5) & 255);
          write_byte(i, refm[i]); // R9 idle write path
        end
        run_burst(len, (c & 1) * 2, ((c >> 1) & 1) * 3, ((c >> 2) & 1) * 9,
                  ((c >> 3) & 1) * 2, (c == 5));
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule